// File: doc/BRIEF.md
# Thresholded Three-Step Motion Search

This block finds a motion vector for one 16x16 macroblock of the current picture against a reference picture held in external memory. The search runs coarse to fine. A 7x7 grid of displacements spaced five pixels apart comes first. Then come eight neighbours at distance two around the best point so far, and last eight neighbours at distance one around the new best point. Each candidate is scored by the sum of absolute differences (SAD) over all 256 pixels. The pixels are fetched one pair per cycle through two synchronous read ports, one for the current block and one for the reference picture.

A caller places the macroblock origin and a distortion threshold on the inputs and pulses `start`. The search stops early when a candidate scores below the threshold. Candidates that leave the ±16 window or the reference picture are passed over at the cost of one cycle. When `done` pulses, the outputs give the winning vector, its SAD, the number of SADs computed and whether the search stopped early. These results are held until the next start.

Top module: `tss_search`

## Requirements
- R1: After reset, `busy`, `done`, `earlyExit`, `bestSad`, `candCount`, `bestDx` and `bestDy` are all zero.
- R2: The first layer visits the offsets -15, -10, -5, 0, +5, +10, +15 on each axis, row by row: dy is the outer loop and dx the inner loop, both ascending. The candidate (5,-5) is therefore the 19th candidate at an interior position.
- R3: The second and third layers each visit the 8 neighbours of the current best vector, at distance 2 and then 1. The order is (-1,-1),(0,-1),(1,-1),(-1,0),(1,0),(-1,1),(0,1),(1,1), scaled by the distance. Any candidate with |dx| or |dy| above 16 is skipped.
- R4: The distortion of a candidate is the SAD of 256 8-bit pixel pairs, and `bestSad` reports the distortion of the winning candidate.
- R5: When the search does not stop early, the result is the candidate with the lowest distortion. On equal distortion, the candidate evaluated first is kept. `bestDx` and `bestDy` are 6-bit two's complement.
- R6: `thr` is sampled when a search starts. The first candidate whose distortion is strictly less than it ends the search with `earlyExit`=1, and that candidate is the result. A distortion equal to the threshold does not end the search.
- R7: A candidate whose block would leave the reference picture is skipped and not counted. `candCount` gives the number of SADs computed, at most 65, and it is exactly 65 for a full search with every candidate inside the picture.
- R8: `start` is accepted only while `busy` is low. `done` is a one-cycle pulse in the last busy cycle. The outputs stay unchanged while the block is idle.
- R9: `curAddr` = row*16+col, and `refAddr` = (mbY+dy+row)*FRAME_W + (mbX+dx+col). Read data is expected on the cycle after the address. Both addresses are zero outside pixel fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search (accepted while idle) |
| mbX | input | XW | Macroblock left column in the reference picture |
| mbY | input | YW | Macroblock top row in the reference picture |
| thr | input | SAD_W | Early-exit distortion threshold |
| curAddr | output | 8 | Current-block pixel index |
| curData | input | PIX_W | Current pixel, one cycle after address |
| refAddr | output | AW | Reference picture pixel index |
| refData | input | PIX_W | Reference pixel, one cycle after address |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| bestDx | output | VEC_W | Winning horizontal displacement |
| bestDy | output | VEC_W | Winning vertical displacement |
| bestSad | output | SAD_W | Distortion of the winner |
| candCount | output | CNT_W | SADs computed |
| earlyExit | output | 1 | Search ended below threshold |

## Verification
The hardest outcomes to provoke from the ports are the tie rule and an early exit that lands on a known candidate. Random pixels almost never produce equal scores or a score below a chosen threshold at a chosen place. The stimulus therefore uses a flat picture, where every candidate scores zero, so the tie rule alone picks the winner. It also copies the current block out of random reference data at an exact grid offset, which makes a single zero-SAD candidate whose position in the visit order is known. Random and noisy displaced blocks at edge and corner origins are then compared against a behavioural search in the bench.

// File: rtl/tss_pkg.sv
package tss_pkg;
  localparam int MB_LOG = 4;
  localparam int MB_DIM = 1 << MB_LOG;
  localparam int PIX_IDX_W = 2 * MB_LOG;
  localparam int NBR_N = 8;

  typedef struct packed {
    logic init;
    logic accum;
    logic evaluate;
  } tssStrobe_t;

  // neighbour order: row above, same row, row below; left to right
  function automatic int nbrX(input logic [2:0] i);
    case (i)
      3'd0, 3'd3, 3'd5: nbrX = -1;
      3'd1, 3'd6:       nbrX = 0;
      default:          nbrX = 1;
    endcase
  endfunction

  function automatic int nbrY(input logic [2:0] i);
    if (i < 3'd3) nbrY = -1;
    else if (i < 3'd5) nbrY = 0;
    else nbrY = 1;
  endfunction
endpackage

// File: rtl/tss_datapath.sv
module tss_datapath
  import tss_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int SAD_W = 16,
  parameter int VEC_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  tssStrobe_t              strobe,
  input  logic [SAD_W-1:0]        thr,
  input  logic [PIX_W-1:0]        curPix,
  input  logic [PIX_W-1:0]        refPix,
  input  logic signed [VEC_W-1:0] candDx,
  input  logic signed [VEC_W-1:0] candDy,
  output logic                    below,
  output logic signed [VEC_W-1:0] bestDx,
  output logic signed [VEC_W-1:0] bestDy,
  output logic [SAD_W-1:0]        bestSad
);
  logic [SAD_W-1:0] acc;
  logic [SAD_W-1:0] thrReg;
  logic [PIX_W-1:0] absDiff;

  assign absDiff = (curPix > refPix) ? (curPix - refPix) : (refPix - curPix);
  assign below = acc < thrReg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc     <= '0;
      thrReg  <= '0;
      bestDx  <= '0;
      bestDy  <= '0;
      bestSad <= '0;
    end else if (strobe.init) begin
      acc     <= '0;
      thrReg  <= thr;
      bestDx  <= '0;
      bestDy  <= '0;
      bestSad <= '1;
    end else if (strobe.evaluate) begin
      if (acc < bestSad) begin
        bestSad <= acc;
        bestDx  <= candDx;
        bestDy  <= candDy;
      end
      acc <= '0;
    end else if (strobe.accum) begin
      acc <= acc + SAD_W'(absDiff);
    end
  end
endmodule

// File: rtl/tss_ctrl.sv
module tss_ctrl
  import tss_pkg::*;
#(
  parameter int FRAME_W = 48,
  parameter int FRAME_H = 48,
  parameter int RANGE = 16,
  parameter int COARSE_STEP = 5,
  parameter int GRID_HALF = 3,
  parameter int FINE_STEP = 2,
  parameter int VEC_W = 6,
  parameter int XW = 6,
  parameter int YW = 6,
  parameter int AW = 12,
  parameter int CNT_W = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [XW-1:0]           mbX,
  input  logic [YW-1:0]           mbY,
  input  logic                    below,
  input  logic signed [VEC_W-1:0] bestDx,
  input  logic signed [VEC_W-1:0] bestDy,
  output tssStrobe_t              strobe,
  output logic signed [VEC_W-1:0] candDx,
  output logic signed [VEC_W-1:0] candDy,
  output logic [PIX_IDX_W-1:0]    curAddr,
  output logic [AW-1:0]           refAddr,
  output logic                    busy,
  output logic                    done,
  output logic                    earlyExit,
  output logic [CNT_W-1:0]        candCount
);
  localparam int GRID_N = 2 * GRID_HALF + 1;
  localparam int GW = $clog2(GRID_N);
  localparam logic [GW-1:0] GRID_LAST = GW'(GRID_N - 1);
  localparam logic [PIX_IDX_W-1:0] PIX_LAST = '1;

  typedef enum logic [2:0] {S_IDLE, S_PICK, S_READ, S_DRAIN, S_EVAL, S_LAYER, S_DONE} state_t;
  state_t state;

  logic [1:0]              layer;
  logic [GW-1:0]           gx, gy;
  logic [2:0]              nIdx;
  logic [PIX_IDX_W-1:0]    pix;
  logic signed [VEC_W-1:0] cenX, cenY;
  logic [XW-1:0]           mbXr;
  logic [YW-1:0]           mbYr;
  logic                    accumPipe;
  int                      cdx, cdy, stepSz, refIdx;
  logic                    candOk, lastInLayer, advance;

  always_comb begin
    stepSz = (layer == 2'd1) ? FINE_STEP : 1;
    if (layer == 2'd0) begin
      cdx = (int'(gx) - GRID_HALF) * COARSE_STEP;
      cdy = (int'(gy) - GRID_HALF) * COARSE_STEP;
    end else begin
      cdx = int'(cenX) + nbrX(nIdx) * stepSz;
      cdy = int'(cenY) + nbrY(nIdx) * stepSz;
    end
  end

  assign candOk = (cdx >= -RANGE) && (cdx <= RANGE) && (cdy >= -RANGE) && (cdy <= RANGE)
               && (int'(mbXr) + cdx >= 0) && (int'(mbXr) + cdx <= FRAME_W - MB_DIM)
               && (int'(mbYr) + cdy >= 0) && (int'(mbYr) + cdy <= FRAME_H - MB_DIM);
  assign lastInLayer = (layer == 2'd0) ? (gx == GRID_LAST && gy == GRID_LAST) : (nIdx == 3'(NBR_N - 1));
  assign advance = (state == S_PICK && !candOk) || (state == S_EVAL && !below);

  assign candDx = VEC_W'(cdx);
  assign candDy = VEC_W'(cdy);

  assign refIdx = (int'(mbYr) + cdy + int'(pix[PIX_IDX_W-1:MB_LOG])) * FRAME_W
                + int'(mbXr) + cdx + int'(pix[MB_LOG-1:0]);
  assign refAddr = (state == S_READ) ? AW'(refIdx) : '0;
  assign curAddr = (state == S_READ) ? pix : '0;

  assign strobe.init     = (state == S_IDLE) && start;
  assign strobe.accum    = accumPipe;
  assign strobe.evaluate = (state == S_EVAL);
  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      layer     <= '0;
      gx        <= '0;
      gy        <= '0;
      nIdx      <= '0;
      pix       <= '0;
      cenX      <= '0;
      cenY      <= '0;
      mbXr      <= '0;
      mbYr      <= '0;
      accumPipe <= 1'b0;
      earlyExit <= 1'b0;
      candCount <= '0;
    end else begin
      accumPipe <= (state == S_READ);
      case (state)
        S_IDLE: if (start) begin
          mbXr      <= mbX;
          mbYr      <= mbY;
          layer     <= '0;
          gx        <= '0;
          gy        <= '0;
          nIdx      <= '0;
          cenX      <= '0;
          cenY      <= '0;
          earlyExit <= 1'b0;
          candCount <= '0;
          state     <= S_PICK;
        end
        S_PICK: if (candOk) begin
          pix   <= '0;
          state <= S_READ;
        end
        S_READ: begin
          pix <= pix + 1'b1;
          if (pix == PIX_LAST) state <= S_DRAIN;
        end
        S_DRAIN: state <= S_EVAL;
        S_EVAL: begin
          candCount <= candCount + 1'b1;
          if (below) begin
            earlyExit <= 1'b1;
            state     <= S_DONE;
          end
        end
        S_LAYER: begin
          cenX  <= bestDx;
          cenY  <= bestDy;
          layer <= layer + 1'b1;
          nIdx  <= '0;
          state <= S_PICK;
        end
        S_DONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
      if (advance) begin
        if (lastInLayer) begin
          state <= (layer == 2'd2) ? S_DONE : S_LAYER;
        end else begin
          state <= S_PICK;
          if (layer == 2'd0) begin
            if (gx == GRID_LAST) begin
              gx <= '0;
              gy <= gy + 1'b1;
            end else begin
              gx <= gx + 1'b1;
            end
          end else begin
            nIdx <= nIdx + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/tss_search.sv
module tss_search
  import tss_pkg::*;
#(
  parameter int FRAME_W = 48,
  parameter int FRAME_H = 48,
  parameter int PIX_W = 8,
  parameter int SAD_W = 16,
  parameter int RANGE = 16,
  parameter int COARSE_STEP = 5,
  parameter int GRID_HALF = 3,
  parameter int FINE_STEP = 2,
  parameter int VEC_W = 6,
  parameter int XW = $clog2(FRAME_W),
  parameter int YW = $clog2(FRAME_H),
  parameter int AW = $clog2(FRAME_W * FRAME_H),
  parameter int MAX_CAND = (2 * GRID_HALF + 1) * (2 * GRID_HALF + 1) + 2 * NBR_N,
  parameter int CNT_W = $clog2(MAX_CAND + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [XW-1:0]           mbX,
  input  logic [YW-1:0]           mbY,
  input  logic [SAD_W-1:0]        thr,
  output logic [PIX_IDX_W-1:0]    curAddr,
  input  logic [PIX_W-1:0]        curData,
  output logic [AW-1:0]           refAddr,
  input  logic [PIX_W-1:0]        refData,
  output logic                    busy,
  output logic                    done,
  output logic signed [VEC_W-1:0] bestDx,
  output logic signed [VEC_W-1:0] bestDy,
  output logic [SAD_W-1:0]        bestSad,
  output logic [CNT_W-1:0]        candCount,
  output logic                    earlyExit
);
  tssStrobe_t              strobe;
  logic                    below;
  logic signed [VEC_W-1:0] candDx, candDy;

  tss_ctrl #(
    .FRAME_W(FRAME_W), .FRAME_H(FRAME_H), .RANGE(RANGE), .COARSE_STEP(COARSE_STEP),
    .GRID_HALF(GRID_HALF), .FINE_STEP(FINE_STEP), .VEC_W(VEC_W), .XW(XW), .YW(YW),
    .AW(AW), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .mbX(mbX), .mbY(mbY), .below(below),
    .bestDx(bestDx), .bestDy(bestDy), .strobe(strobe), .candDx(candDx), .candDy(candDy),
    .curAddr(curAddr), .refAddr(refAddr), .busy(busy), .done(done),
    .earlyExit(earlyExit), .candCount(candCount)
  );

  tss_datapath #(.PIX_W(PIX_W), .SAD_W(SAD_W), .VEC_W(VEC_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .thr(thr), .curPix(curData),
    .refPix(refData), .candDx(candDx), .candDy(candDy), .below(below),
    .bestDx(bestDx), .bestDy(bestDy), .bestSad(bestSad)
  );
endmodule

// File: rtl/tss_search_chk.sv
module tss_search_chk #(
  parameter int FRAME_W = 48,
  parameter int FRAME_H = 48,
  parameter int RANGE = 16,
  parameter int SAD_W = 16,
  parameter int VEC_W = 6,
  parameter int AW = 12,
  parameter int CNT_W = 7,
  parameter int MAX_CAND = 65
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start,
  input logic [SAD_W-1:0]        thr,
  input logic                    busy,
  input logic                    done,
  input logic signed [VEC_W-1:0] bestDx,
  input logic signed [VEC_W-1:0] bestDy,
  input logic [SAD_W-1:0]        bestSad,
  input logic [CNT_W-1:0]        candCount,
  input logic                    earlyExit,
  input logic [AW-1:0]           refAddr
);
  logic [SAD_W-1:0] thrSeen;

  always_ff @(posedge clk) begin
    if (!rst_n) thrSeen <= '0;
    else if (start && !busy) thrSeen <= thr;
  end

  // R7
  count_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(candCount) <= MAX_CAND);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R3
  vec_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (int'(bestDx) >= -RANGE && int'(bestDx) <= RANGE &&
              int'(bestDy) >= -RANGE && int'(bestDy) <= RANGE));

  // R6
  early_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && earlyExit) |-> (bestSad < thrSeen));

  // R6
  full_not_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !earlyExit) |-> (bestSad >= thrSeen));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(bestSad) && $stable(candCount) && $stable(bestDx) && $stable(bestDy)));

  // R9
  ref_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(refAddr) < FRAME_W * FRAME_H);
endmodule

bind tss_search tss_search_chk #(
  .FRAME_W(FRAME_W), .FRAME_H(FRAME_H), .RANGE(RANGE), .SAD_W(SAD_W), .VEC_W(VEC_W),
  .AW(AW), .CNT_W(CNT_W), .MAX_CAND(MAX_CAND)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .thr(thr), .busy(busy), .done(done),
  .bestDx(bestDx), .bestDy(bestDy), .bestSad(bestSad), .candCount(candCount),
  .earlyExit(earlyExit), .refAddr(refAddr)
);

// File: tb/tss_search_bench.sv
`timescale 1ns/100ps
module tss_search_bench;
  localparam int FW = 48;
  localparam int FH = 48;
  localparam int LIMIT = 195000;
  localparam int NVEC = 5;
  // mbX, mbY, thr, mode (0 random block, 1 displaced noisy copy), dispX, dispY
  localparam int VEC [NVEC][6] = '{
    '{16, 16, 0,     1,  6, -4},
    '{0,  0,  0,     0,  0,  0},
    '{32, 32, 3000,  1, -7, -9},
    '{8,  24, 0,     1, 13,-16},
    '{24, 5,  65535, 0,  0,  0}
  };

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0;
  logic [5:0] mbX = 0, mbY = 0;
  logic [15:0] thr = 0;
  logic [7:0] curAddr, curData;
  logic [11:0] refAddr;
  logic [7:0] refData;
  logic busy, done, earlyExit;
  logic signed [5:0] bestDx, bestDy;
  logic [15:0] bestSad;
  logic [6:0] candCount;

  logic [7:0] refMem [FW*FH];
  logic [7:0] curMem [256];

  int errors = 0, checks = 0, cycles = 0;
  bit timedOut = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;
  always @(posedge clk) begin
    refData <= refMem[refAddr];
    curData <= curMem[curAddr];
  end

  tss_search u_tss_search (
    .clk(clk), .rst_n(rst_n), .start(start), .mbX(mbX), .mbY(mbY), .thr(thr),
    .curAddr(curAddr), .curData(curData), .refAddr(refAddr), .refData(refData),
    .busy(busy), .done(done), .bestDx(bestDx), .bestDy(bestDy), .bestSad(bestSad),
    .candCount(candCount), .earlyExit(earlyExit)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int blockSad(input int x, input int y);
    int s = 0;
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 16; c++) begin
        int a = curMem[r*16+c];
        int b = refMem[(y+r)*FW + x + c];
        s += (a > b) ? a - b : b - a;
      end
    return s;
  endfunction

  task automatic refSearch(input int mx, input int my, input int th,
                           output int bx, output int by, output int bs,
                           output int cnt, output int ee);
    int cx = 0, cy = 0, best = 1 << 30;
    bit stop = 0;
    bx = 0; by = 0; cnt = 0; ee = 0;
    for (int layer = 0; layer < 3 && !stop; layer++) begin
      int num = (layer == 0) ? 49 : 8;
      for (int k = 0; k < num && !stop; k++) begin
        int dx, dy, s;
        if (layer == 0) begin
          dx = -15 + 5 * (k % 7);
          dy = -15 + 5 * (k / 7);
        end else begin
          int nx = (k < 3) ? k - 1 : (k == 3) ? -1 : (k == 4) ? 1 : k - 6;
          int ny = (k < 3) ? -1 : (k < 5) ? 0 : 1;
          int st = (layer == 1) ? 2 : 1;
          dx = cx + nx * st;
          dy = cy + ny * st;
        end
        if (dx < -16 || dx > 16 || dy < -16 || dy > 16) continue;
        if (mx + dx < 0 || mx + dx > FW - 16 || my + dy < 0 || my + dy > FH - 16) continue;
        s = blockSad(mx + dx, my + dy);
        cnt++;
        if (s < best) begin best = s; bx = dx; by = dy; end
        if (s < th) begin ee = 1; stop = 1; end
      end
      cx = bx; cy = by;
    end
    bs = best;
  endtask

  task automatic runSearch(input int mx, input int my, input int th, input int thLater);
    @(negedge clk);
    mbX = 6'(mx); mbY = 6'(my); thr = 16'(th); start = 1;
    @(negedge clk);
    start = 0; thr = 16'(thLater);
    while (!done && !timedOut) begin
      @(negedge clk);
      if (cycles > LIMIT) timedOut = 1;
    end
  endtask

  task automatic fillRefRandom();
    for (int i = 0; i < FW*FH; i++) refMem[i] = 8'($urandom);
  endtask

  task automatic copyBlock(input int x, input int y, input int noiseMask);
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 16; c++)
        curMem[r*16+c] = refMem[(y+r)*FW + x + c] ^ 8'($urandom & noiseMask);
  endtask

  initial begin
    int bx, by, bs, cnt, ee;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 bestSad", int'(bestSad), 0);
    chk("R1 candCount", int'(candCount), 0);
    chk("R1 earlyExit", int'(earlyExit), 0);
    rst_n = 1;

    // flat picture: all candidates tie at zero
    for (int i = 0; i < FW*FH; i++) refMem[i] = 8'd77;
    for (int i = 0; i < 256; i++) curMem[i] = 8'd77;
    runSearch(16, 16, 0, 0);
    chk("R5 tie keeps first dx", int'(bestDx), -15);
    chk("R5 tie keeps first dy", int'(bestDy), -15);
    chk("R3 out-of-window neighbours skipped, count", int'(candCount), 60);
    chk("R6 no early exit on equal", int'(earlyExit), 0);
    runSearch(16, 16, 1, 1);
    chk("R6 early exit count", int'(candCount), 1);
    chk("R6 early exit flag", int'(earlyExit), 1);

    // exact copy at grid point (5,-5); threshold raised after start must be ignored
    fillRefRandom();
    copyBlock(21, 11, 0);
    runSearch(16, 16, 0, 65535);
    chk("R9 exact match sad", int'(bestSad), 0);
    chk("R5 exact match dx", int'(bestDx), 5);
    chk("R5 exact match dy", int'(bestDy), -5);
    chk("R7 full search count", int'(candCount), 65);
    chk("R6 threshold sampled at start", int'(earlyExit), 0);
    runSearch(16, 16, 1, 1);
    chk("R2 grid order count", int'(candCount), 19);
    chk("R2 early at (5,-5) dx", int'(bestDx), 5);
    chk("R6 early flag", int'(earlyExit), 1);
    @(negedge clk);
    chk("R8 done is one cycle", int'(done), 0);
    chk("R8 busy low after done", int'(busy), 0);
    repeat (5) @(negedge clk);
    chk("R8 result held count", int'(candCount), 19);
    chk("R8 result held sad", int'(bestSad), 0);

    // vector table against the behavioural search
    for (int v = 0; v < NVEC; v++) begin
      fillRefRandom();
      if (VEC[v][3] == 1) copyBlock(VEC[v][0] + VEC[v][4], VEC[v][1] + VEC[v][5], 3);
      else for (int i = 0; i < 256; i++) curMem[i] = 8'($urandom);
      refSearch(VEC[v][0], VEC[v][1], VEC[v][2], bx, by, bs, cnt, ee);
      runSearch(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][2]);
      chk("R3/R5 bestDx", int'(bestDx), bx);
      chk("R3/R5 bestDy", int'(bestDy), by);
      chk("R4 bestSad", int'(bestSad), bs);
      chk("R7 candCount", int'(candCount), cnt);
      chk("R6 earlyExit", int'(earlyExit), ee);
    end

    if (timedOut) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, LIMIT);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule